// File: doc/BRIEF.md
# ADC Sampling Phase Trigger Controller

This block sits between the trigger sources of an analog-to-digital converter and its analog front end. It decides when the sampling switch is closed and when the conversion proper is launched. It drives a level `sample_en` for the sampling switch and a one-cycle `convert_start` pulse to the converter. It then waits for the converter's end-of-conversion strobe before it accepts another start.

Three timing schemes are supported:
- **Counted mode.** A start event opens sampling for a programmed number of clock cycles.
- **Edge-window mode.** The two edges of the start source bound the sampling window: the rising edge opens it and the falling edge closes it and launches the conversion. The start source is either the hardware trigger or a software-held level bit.
- **Continuous mode.** After a first counted sample, the switch closes again as soon as each conversion ends. The next start event then launches the conversion directly.

The two mode bits exclude each other. If both are set, the block flags an error and refuses to start.

The hardware trigger is treated as a synchronous level, and only its rising edge starts work. The mode bits are expected to change only while no conversion is running.

Top module: `adc_smp_phase_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released with no stimulus, `sample_en`, `convert_start` and `cfg_err` are all 0.
- R2: Counted mode with hardware triggering (`hw_trig_en`=1, both mode bits 0). A rising edge of `hw_trig` raises `sample_en` in the next cycle for N cycles, where N is `smp_cycles` and a value of 0 counts as 1. `convert_start` is then 1 for exactly the first cycle in which `sample_en` is low again.
- R3: Counted mode with software triggering (`hw_trig_en`=0). With `sw_samp_bit`=1, a `sw_start` pulse behaves like the hardware edge in R2. With `sw_samp_bit`=0, a `sw_start` pulse gives `convert_start`=1 in the next cycle, and `sample_en` stays 0.
- R4: Edge-window mode with hardware triggering (`trig_ctl_mode`=1, `hw_trig_en`=1). `sample_en` is 1 for exactly as many cycles as `hw_trig` was held high, delayed by one cycle. `convert_start` is 1 in the cycle after the falling edge is seen.
- R5: Edge-window mode with software triggering (`hw_trig_en`=0). A 0-to-1 change of `sw_samp_bit` opens sampling and a 1-to-0 change launches the conversion, with the same timing as R4. `sw_start` has no effect in this mode.
- R6: Continuous mode (`bulb_mode`=1). The first start uses the counted sampling time of R2/R3. In the cycle after `eoc`, `sample_en` is 1 and it stays 1 until a start event. That start event gives `convert_start` in the next cycle, with `sample_en` 0.
- R7: If `trig_ctl_mode` and `bulb_mode` are both 1, `cfg_err` is 1 from the next cycle on. While idle, no start event raises `sample_en` or `convert_start`. `cfg_err` returns to 0 one cycle after the conflict is removed.
- R8: From `convert_start` until the cycle in which `eoc` is seen, every trigger is ignored and `sample_en` stays 0. A trigger edge in the same cycle as `eoc` is also dropped.
- R9: `convert_start` never lasts more than one cycle and is never 1 together with `sample_en`.
- R10: Clearing `bulb_mode` while the block is waiting in continuous sampling brings `sample_en` to 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_trig | input | 1 | Hardware trigger level (synchronous) |
| hw_trig_en | input | 1 | 1: rising-edge hardware triggering; 0: software start |
| sw_start | input | 1 | One-cycle software start pulse |
| sw_samp_bit | input | 1 | Software level bit: sampling-first select, or the window level in edge-window mode |
| smp_cycles | input | CNT_W | Programmed sampling time in cycles (0 counts as 1) |
| eoc | input | 1 | End-of-conversion strobe from the converter |
| trig_ctl_mode | input | 1 | Edge-window mode select |
| bulb_mode | input | 1 | Continuous-sampling mode select |
| sample_en | output | 1 | Sampling switch enable |
| convert_start | output | 1 | One-cycle conversion launch |
| cfg_err | output | 1 | Both mode bits set |

## Verification
Two pairs of functions can meet in one cycle, and the bench forces both.

The first pair is end of conversion and a new trigger edge. The bench raises `hw_trig` in the very cycle `eoc` is pulsed. In counted mode it then requires that no sampling follows. In continuous mode it requires that sampling resumes but no conversion is launched.

The second pair is the error flag and a start. The bench sets both mode bits and fires a hardware edge. It requires the error flag to be high while both outputs stay low.

// File: rtl/adc_smp_pkg.sv
package adc_smp_pkg;
  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_COUNT  = 3'd1,
    PH_WINDOW = 3'd2,
    PH_CONV   = 3'd3,
    PH_BULB   = 3'd4
  } phase_t;
endpackage

// File: rtl/adc_smp_rst_sync.sv
module adc_smp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/adc_smp_edge_det.sv
module adc_smp_edge_det #(
  parameter int NSIG = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSIG-1:0] sig,
  output logic [NSIG-1:0] rise,
  output logic [NSIG-1:0] fall
);
  logic [NSIG-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= sig;
  end

  for (genvar i = 0; i < NSIG; i++) begin : g_edge
    assign rise[i] = sig[i] & ~prev_q[i];
    assign fall[i] = ~sig[i] & prev_q[i];
  end
endmodule

// File: rtl/adc_smp_time_cnt.sv
module adc_smp_time_cnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic             last
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)     cnt_d = (load_val == '0) ? ONE : load_val;
    else if (dec) cnt_d = cnt_q - ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (load | dec) cnt_q <= cnt_d;
  end

  assign last = (cnt_q == ONE);

  // R2: counting never runs below one
  assert_no_underflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    dec |-> (cnt_q != '0));
endmodule

// File: rtl/adc_smp_phase_ctrl.sv
module adc_smp_phase_ctrl
  import adc_smp_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hw_trig,
  input  logic             hw_trig_en,
  input  logic             sw_start,
  input  logic             sw_samp_bit,
  input  logic [CNT_W-1:0] smp_cycles,
  input  logic             eoc,
  input  logic             trig_ctl_mode,
  input  logic             bulb_mode,
  output logic             sample_en,
  output logic             convert_start,
  output logic             cfg_err
);
  localparam int HW_IDX = 0;
  localparam int SW_IDX = 1;

  logic       rst_n_int;
  logic [1:0] edge_rise, edge_fall;
  logic       start_evt, win_open, win_close, conflict;
  logic       cnt_load, cnt_dec, cnt_last;
  phase_t     ph_q, ph_d;
  logic       conv_d, sample_d;
  logic       sample_q, conv_q, err_q;

  adc_smp_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_int));

  adc_smp_edge_det #(.NSIG(2)) u_edge (
    .clk(clk), .rst_n(rst_n_int), .sig({sw_samp_bit, hw_trig}),
    .rise(edge_rise), .fall(edge_fall));

  adc_smp_time_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n_int), .load(cnt_load), .load_val(smp_cycles),
    .dec(cnt_dec), .last(cnt_last));

  assign conflict  = trig_ctl_mode & bulb_mode;
  assign start_evt = hw_trig_en ? edge_rise[HW_IDX] : sw_start;
  assign win_open  = hw_trig_en ? edge_rise[HW_IDX] : edge_rise[SW_IDX];
  assign win_close = hw_trig_en ? edge_fall[HW_IDX] : edge_fall[SW_IDX];
  assign cnt_dec   = (ph_q == PH_COUNT);

  always_comb begin
    ph_d     = ph_q;
    cnt_load = 1'b0;
    conv_d   = 1'b0;
    unique case (ph_q)
      PH_IDLE: begin
        if (!conflict) begin
          if (trig_ctl_mode) begin
            if (win_open) ph_d = PH_WINDOW;
          end else if (start_evt) begin
            if (bulb_mode || hw_trig_en || sw_samp_bit) begin
              ph_d     = PH_COUNT;
              cnt_load = 1'b1;
            end else begin
              ph_d   = PH_CONV;
              conv_d = 1'b1;
            end
          end
        end
      end
      PH_COUNT: begin
        if (cnt_last) begin
          ph_d   = PH_CONV;
          conv_d = 1'b1;
        end
      end
      PH_WINDOW: begin
        if (win_close) begin
          ph_d   = PH_CONV;
          conv_d = 1'b1;
        end
      end
      PH_CONV: begin
        if (eoc) ph_d = (bulb_mode && !conflict) ? PH_BULB : PH_IDLE;
      end
      PH_BULB: begin
        if (conflict || !bulb_mode) begin
          ph_d = PH_IDLE;
        end else if (start_evt) begin
          ph_d   = PH_CONV;
          conv_d = 1'b1;
        end
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  assign sample_d = (ph_d == PH_COUNT) || (ph_d == PH_WINDOW) || (ph_d == PH_BULB);

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      ph_q     <= PH_IDLE;
      sample_q <= 1'b0;
      conv_q   <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      ph_q     <= ph_d;
      sample_q <= sample_d;
      conv_q   <= conv_d;
      err_q    <= conflict;
    end
  end

  assign sample_en     = sample_q;
  assign convert_start = conv_q;
  assign cfg_err       = err_q;

  // R9: launch pulse is one cycle wide
  assert_conv_single_R9: assert property (@(posedge clk) disable iff (!rst_n_int)
    convert_start |=> !convert_start);
  // R9: launch never overlaps sampling
  assert_conv_not_sampling_R9: assert property (@(posedge clk) disable iff (!rst_n_int)
    convert_start |-> !sample_en);
  // R7: a conflicting configuration blocks any start from idle
  assert_refuse_start_R7: assert property (@(posedge clk) disable iff (!rst_n_int)
    (ph_q == PH_IDLE && conflict) |=> (!sample_en && !convert_start));
  // R8: nothing starts while a conversion is outstanding
  assert_busy_ignore_R8: assert property (@(posedge clk) disable iff (!rst_n_int)
    (ph_q == PH_CONV && !eoc) |=> (!sample_en && !convert_start));
  // R6: continuous mode resamples right after end of conversion
  assert_bulb_restart_R6: assert property (@(posedge clk) disable iff (!rst_n_int)
    (ph_q == PH_CONV && eoc && bulb_mode && !trig_ctl_mode) |=> sample_en);
endmodule

// File: tb/adc_smp_phase_ctrl_tb.sv
module adc_smp_phase_ctrl_tb;
  localparam int CNT_W = 8;

  logic clk = 1'b0;
  logic rst_n, hw_trig, hw_trig_en, sw_start, sw_samp_bit, eoc;
  logic trig_ctl_mode, bulb_mode;
  logic [CNT_W-1:0] smp_cycles;
  logic sample_en, convert_start, cfg_err;

  int n_tests = 0;
  int n_fail  = 0;

  always #4 clk = ~clk;

  adc_smp_phase_ctrl #(.CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .hw_trig(hw_trig), .hw_trig_en(hw_trig_en),
    .sw_start(sw_start), .sw_samp_bit(sw_samp_bit), .smp_cycles(smp_cycles),
    .eoc(eoc), .trig_ctl_mode(trig_ctl_mode), .bulb_mode(bulb_mode),
    .sample_en(sample_en), .convert_start(convert_start), .cfg_err(cfg_err));

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check(string req, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic measure(string req, int exp_len);
    int n = 0;
    while (sample_en === 1'b1 && n < 600) begin
      n++;
      step();
    end
    check({req, " sample length"}, n, exp_len);
    check({req, " launch after sampling"}, int'(convert_start), 1);
    step();
    check({req, " launch width"}, int'(convert_start), 0);
  endtask

  task automatic end_conv();
    eoc = 1'b1;
    step();
    eoc = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int hi;
    rst_n = 1'b0; hw_trig = 0; hw_trig_en = 1; sw_start = 0; sw_samp_bit = 0;
    eoc = 0; trig_ctl_mode = 0; bulb_mode = 0; smp_cycles = '0;

    // R1: reset state
    repeat (3) step();
    check("R1 sample_en in reset", int'(sample_en), 0);
    check("R1 convert_start in reset", int'(convert_start), 0);
    check("R1 cfg_err in reset", int'(cfg_err), 0);
    rst_n = 1'b1;
    repeat (4) step();
    check("R1 idle sample_en", int'(sample_en), 0);
    check("R1 idle convert_start", int'(convert_start), 0);
    check("R1 idle cfg_err", int'(cfg_err), 0);

    // R2 and R8: hardware counted sweep, with triggers while busy
    for (int n = 0; n < 10; n++) begin
      smp_cycles = CNT_W'(n);
      hw_trig = 1'b1;
      step();
      measure("R2", (n == 0) ? 1 : n);
      hw_trig = 1'b0;
      step();
      hw_trig = 1'b1;
      step();
      check("R8 busy trigger ignored", int'(sample_en), 0);
      check("R8 busy no launch", int'(convert_start), 0);
      hw_trig = 1'b0;
      step();
      end_conv();
      step();
      check("R2 back to idle", int'(sample_en), 0);
    end

    // R8: trigger edge in the same cycle as end of conversion (counted mode)
    smp_cycles = 8'd2;
    hw_trig = 1'b1;
    step();
    measure("R2 pre-coincidence", 2);
    hw_trig = 1'b0;
    step();
    eoc = 1'b1; hw_trig = 1'b1;
    step();
    eoc = 1'b0;
    repeat (3) begin
      step();
      check("R8 coincident edge dropped", int'(sample_en), 0);
    end
    hw_trig = 1'b0;
    step();

    // R3: software start, sampling first
    hw_trig_en = 1'b0; sw_samp_bit = 1'b1;
    for (int n = 1; n < 7; n++) begin
      smp_cycles = CNT_W'(n);
      sw_start = 1'b1;
      step();
      sw_start = 1'b0;
      measure("R3", n);
      end_conv();
    end

    // R3: software start, conversion directly
    sw_samp_bit = 1'b0;
    step();
    sw_start = 1'b1;
    step();
    sw_start = 1'b0;
    check("R3 direct launch", int'(convert_start), 1);
    check("R3 direct no sampling", int'(sample_en), 0);
    step();
    check("R3 direct launch width", int'(convert_start), 0);
    end_conv();

    // R4: edge window driven by hardware trigger
    trig_ctl_mode = 1'b1; hw_trig_en = 1'b1;
    step();
    for (int h = 1; h < 9; h++) begin
      hi = 0;
      hw_trig = 1'b1;
      repeat (h) begin
        step();
        if (sample_en) hi++;
      end
      hw_trig = 1'b0;
      step();
      check("R4 window length", hi, h);
      check("R4 launch on falling edge", int'(convert_start), 1);
      check("R4 sampling closed", int'(sample_en), 0);
      end_conv();
    end

    // R5: edge window driven by the software level bit
    hw_trig_en = 1'b0;
    step();
    sw_start = 1'b1;
    step();
    sw_start = 1'b0;
    step();
    check("R5 sw_start ignored sample", int'(sample_en), 0);
    check("R5 sw_start ignored launch", int'(convert_start), 0);
    for (int h = 1; h < 7; h++) begin
      hi = 0;
      sw_samp_bit = 1'b1;
      repeat (h) begin
        step();
        if (sample_en) hi++;
      end
      sw_samp_bit = 1'b0;
      step();
      check("R5 window length", hi, h);
      check("R5 launch on clear", int'(convert_start), 1);
      end_conv();
    end

    // R6: continuous mode
    trig_ctl_mode = 1'b0; bulb_mode = 1'b1; hw_trig_en = 1'b1;
    smp_cycles = 8'd3;
    step();
    hw_trig = 1'b1;
    step();
    measure("R6 first counted", 3);
    hw_trig = 1'b0;
    for (int k = 0; k < 3; k++) begin
      end_conv();
      check("R6 resample after eoc", int'(sample_en), 1);
      repeat (4) step();
      check("R6 still sampling", int'(sample_en), 1);
      check("R6 no launch yet", int'(convert_start), 0);
      hw_trig = 1'b1;
      step();
      check("R6 launch on trigger", int'(convert_start), 1);
      check("R6 sampling closed", int'(sample_en), 0);
      hw_trig = 1'b0;
      step();
    end
    // R8: coincident edge and end of conversion in continuous mode
    eoc = 1'b1; hw_trig = 1'b1;
    step();
    eoc = 1'b0;
    check("R8 bulb resample on coincidence", int'(sample_en), 1);
    step();
    check("R8 bulb coincident edge dropped", int'(convert_start), 0);
    check("R8 bulb still sampling", int'(sample_en), 1);
    hw_trig = 1'b0;
    step();

    // R10: leaving continuous mode while waiting
    bulb_mode = 1'b0;
    step();
    check("R10 sampling dropped", int'(sample_en), 0);
    step();

    // R7: conflicting modes
    bulb_mode = 1'b1; trig_ctl_mode = 1'b1;
    step();
    check("R7 error raised", int'(cfg_err), 1);
    hw_trig = 1'b1;
    repeat (3) begin
      step();
      check("R7 refused sample", int'(sample_en), 0);
      check("R7 refused launch", int'(convert_start), 0);
      check("R7 error held", int'(cfg_err), 1);
    end
    hw_trig = 1'b0;
    bulb_mode = 1'b0; trig_ctl_mode = 1'b0;
    step();
    check("R7 error cleared", int'(cfg_err), 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule